// File: doc/BRIEF.md
# Banked CPU Program Address Mapper

This block sits between an 8-bit CPU bus and a cartridge program ROM. It listens to CPU writes in the upper half of the address space and keeps a small set of mapping registers: a bank-select byte, two switchable 8 KB program bank numbers, and a nametable mirroring bit. From these it turns every CPU address in the 32 KB program window into a program-ROM address. The window is split into four 8 KB slots. Two slots are switchable and two are fixed to the last two banks of the ROM. A swap bit in the bank-select byte chooses whether switchable bank 0 appears in the first slot or the third slot.

The ROM size is a parameter counted in 8 KB banks. A write strobe is turned into exactly one commit by a two-state machine. In `WR_IDLE`, a clock edge that sees `cpu_wr` high commits the write and moves to `WR_HELD`. In `WR_HELD`, the machine stays put while `cpu_wr` remains high and returns to `WR_IDLE` on the first edge that sees it low. The mirroring output reports vertical, horizontal, or four-screen. A four-screen input overrides the stored mirroring bit and also blocks writes to it.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, switchable bank 0 is 0, switchable bank 1 is 1, the swap bit is clear, the select index is 0 and mirroring is vertical (code 0).
- R2: A write is decoded only when cpu_addr[15] is 1. The register is chosen by cpu_addr[14:13] together with cpu_addr[0], and cpu_addr[12:1] are ignored. So 0x9FFE acts as 0x8000 and 0x9FFF acts as 0x8001.
- R3: A write to an even address in 0x8000–0x9FFF stores the bank-select byte. Data bits 2:0 become the select index and data bit 6 becomes the swap bit.
- R4: A write to an odd address in 0x8000–0x9FFF loads bank 0 when the select index is 6 and bank 1 when it is 7. With index 0 to 5, the write leaves the program mapping unchanged.
- R5: With the swap bit clear, the four 8 KB slots (cpu_addr[14:13] = 0,1,2,3) map to bank 0, bank 1, the second-to-last bank and the last bank.
- R6: With the swap bit set, the slots map to the second-to-last bank, bank 1, bank 0 and the last bank.
- R7: prg_addr equals the slot's bank number times 8192 plus cpu_addr[12:0]. Bank numbers are taken modulo PRG_BANKS, so for 16 banks a value of 0x13 selects bank 3.
- R8: A write to an even address in 0xA000–0xBFFF with data bit 0 set selects horizontal mirroring (mirror_mode 1). With data bit 0 clear, it selects vertical mirroring (mirror_mode 0).
- R9: While four_screen is high, mirror_mode is 2 and mirroring writes are ignored. When four_screen drops, the bit stored before the override is reported again.
- R10: A write takes effect on the first rising clock edge that sees cpu_wr high. Further edges with cpu_wr still high commit nothing until an edge has seen cpu_wr low.
- R11: Writes to odd addresses in 0xA000–0xBFFF and to any address in 0xC000–0xFFFF change neither prg_addr nor mirror_mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address, used both for register writes and for program reads |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, level sensitive |
| four_screen | input | 1 | Four-screen configuration; overrides mirroring |
| prg_addr | output | $clog2(PRG_BANKS)+13 | Mapped program-ROM byte address |
| mirror_mode | output | 2 | 0 vertical, 1 horizontal, 2 four-screen |

## Verification
The hardest case to reach from the ports is a write strobe held high across several clock edges while the data lines change. Only the first edge may commit; this is the `WR_HELD` path of the state machine. The stimulus raises `cpu_wr` with the select index at 6 and keeps it high for three edges, presenting a different bank number at each. It then probes slot 0 to confirm that only the first value took effect. A second subtle case is a mirroring write made while four-screen is asserted. The stimulus first stores horizontal mirroring, writes vertical under the override, then drops the override and checks that horizontal is reported again.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    // Width of the in-bank byte offset (8 KB banks)
    localparam int OFFSET_BITS = 13;

    // Select-index values that target the program bank registers
    localparam logic [2:0] IDX_BANK0 = 3'd6;
    localparam logic [2:0] IDX_BANK1 = 3'd7;

    // Mirroring code reported at the top
    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORIZ = 2'd1,
        MIR_FOUR  = 2'd2
    } mirror_e;

    // Write-strobe tracking states
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_e;

    // Register key built from {addr[14:13], addr[0]}
    typedef enum logic [2:0] {
        KEY_SELECT = 3'b000,
        KEY_BANKDAT = 3'b001,
        KEY_MIRROR = 3'b010,
        KEY_SPARE3 = 3'b011,
        KEY_SPARE4 = 3'b100,
        KEY_SPARE5 = 3'b101,
        KEY_SPARE6 = 3'b110,
        KEY_SPARE7 = 3'b111
    } reg_key_e;

endpackage

// File: rtl/wr_strobe_fsm.sv
module wr_strobe_fsm
    import prg_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_wr,
    output logic wr_commit
);

    wr_state_e state_q;
    wr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (cpu_wr)  state_d = WR_HELD;
            WR_HELD: if (!cpu_wr) state_d = WR_IDLE;
        endcase
    end

    // Output: one commit per strobe, on the edge that leaves WR_IDLE
    always_comb begin
        wr_commit = 1'b0;
        unique case (state_q)
            WR_IDLE: wr_commit = cpu_wr;
            WR_HELD: wr_commit = 1'b0;
        endcase
    end

    // R10: a commit is never followed by another commit on the next edge
    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R10: a strobe still high after a commit keeps the machine quiet
    a_r10_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && cpu_wr) |=> (cpu_wr |-> !wr_commit));

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int BANK_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_commit,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 four_screen,
    output logic [BANK_BITS-1:0] bank0,
    output logic [BANK_BITS-1:0] bank1,
    output logic                 swap,
    output logic                 mirror_horiz
);

    logic [BANK_BITS-1:0] bank0_q;
    logic [BANK_BITS-1:0] bank1_q;
    logic [2:0]           idx_q;
    logic                 swap_q;
    logic                 mirror_q;

    reg_key_e key;
    logic     reg_hit;
    logic     unused_bits;

    assign key         = reg_key_e'({cpu_addr[14:13], cpu_addr[0]});
    assign reg_hit     = wr_commit && cpu_addr[15];
    assign unused_bits = ^{cpu_addr[12:1], cpu_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank0_q  <= '0;
            bank1_q  <= BANK_BITS'(1);
            idx_q    <= '0;
            swap_q   <= 1'b0;
            mirror_q <= 1'b0;
        end else if (reg_hit) begin
            case (key)
                KEY_SELECT: begin
                    idx_q  <= cpu_data[2:0];
                    swap_q <= cpu_data[6];
                end
                KEY_BANKDAT: begin
                    if (idx_q == IDX_BANK0) bank0_q <= cpu_data[BANK_BITS-1:0];
                    if (idx_q == IDX_BANK1) bank1_q <= cpu_data[BANK_BITS-1:0];
                end
                KEY_MIRROR: begin
                    if (!four_screen) mirror_q <= cpu_data[0];
                end
                default: ;
            endcase
        end
    end

    assign bank0        = bank0_q;
    assign bank1        = bank1_q;
    assign swap         = swap_q;
    assign mirror_horiz = mirror_q;

    // R10: state moves only on a committed write
    a_r10_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable({bank0_q, bank1_q, idx_q, swap_q, mirror_q}));

    // R2: commits below 0x8000 touch nothing
    a_r2_low_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !cpu_addr[15]) |=> $stable({bank0_q, bank1_q, idx_q, swap_q, mirror_q}));

    // R4: bank data with a character index leaves program banks alone
    a_r4_low_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && key == KEY_BANKDAT && idx_q < IDX_BANK0) |=> $stable({bank0_q, bank1_q}));

    // R9: mirroring bit frozen under four-screen
    a_r9_four_screen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        four_screen |=> $stable(mirror_q));

    // R11: spare registers are inert
    a_r11_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && key inside {KEY_SPARE3, KEY_SPARE4, KEY_SPARE5, KEY_SPARE6, KEY_SPARE7})
        |=> $stable({bank0_q, bank1_q, idx_q, swap_q, mirror_q}));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_map_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    localparam int BANK_BITS = $clog2(PRG_BANKS),
    localparam int PRG_AW = BANK_BITS + OFFSET_BITS
) (
    input  logic [14:0]          cpu_off,
    input  logic [BANK_BITS-1:0] bank0,
    input  logic [BANK_BITS-1:0] bank1,
    input  logic                 swap,
    output logic [PRG_AW-1:0]    prg_addr
);

    localparam logic [BANK_BITS-1:0] LAST_BANK   = BANK_BITS'(PRG_BANKS - 1);
    localparam logic [BANK_BITS-1:0] PENULT_BANK = BANK_BITS'(PRG_BANKS - 2);

    logic [1:0]           slot;
    logic [BANK_BITS-1:0] slot_bank [4];
    logic [BANK_BITS-1:0] sel_bank;

    assign slot = cpu_off[14:13];

    always_comb begin
        slot_bank[1] = bank1;
        slot_bank[3] = LAST_BANK;
        if (swap) begin
            slot_bank[0] = PENULT_BANK;
            slot_bank[2] = bank0;
        end else begin
            slot_bank[0] = bank0;
            slot_bank[2] = PENULT_BANK;
        end
        sel_bank = slot_bank[slot];
        prg_addr = {sel_bank, cpu_off[OFFSET_BITS-1:0]};
    end

    // R5/R6: top slot always the last bank, slot 1 always bank 1
    always_comb begin
        a_r5_last_slot_fixed: assert (slot != 2'd3 || prg_addr[PRG_AW-1:OFFSET_BITS] == LAST_BANK);
        a_r6_slot1_bank1: assert (slot != 2'd1 || prg_addr[PRG_AW-1:OFFSET_BITS] == bank1);
        a_r7_offset_passthru: assert (prg_addr[OFFSET_BITS-1:0] == cpu_off[OFFSET_BITS-1:0]);
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    localparam int BANK_BITS = $clog2(PRG_BANKS),
    localparam int PRG_AW = BANK_BITS + OFFSET_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic              four_screen,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [1:0]        mirror_mode
);

    logic                 wr_commit;
    logic [BANK_BITS-1:0] bank0;
    logic [BANK_BITS-1:0] bank1;
    logic                 swap;
    logic                 mirror_horiz;

    wr_strobe_fsm i_wr_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .wr_commit (wr_commit)
    );

    prg_bank_regs #(.BANK_BITS(BANK_BITS)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_commit    (wr_commit),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .four_screen  (four_screen),
        .bank0        (bank0),
        .bank1        (bank1),
        .swap         (swap),
        .mirror_horiz (mirror_horiz)
    );

    prg_window_map #(.PRG_BANKS(PRG_BANKS)) i_map (
        .cpu_off  (cpu_addr[14:0]),
        .bank0    (bank0),
        .bank1    (bank1),
        .swap     (swap),
        .prg_addr (prg_addr)
    );

    always_comb begin
        if (four_screen)       mirror_mode = MIR_FOUR;
        else if (mirror_horiz) mirror_mode = MIR_HORIZ;
        else                   mirror_mode = MIR_VERT;
    end

    // R8: without the override, only vertical or horizontal is reported
    a_r8_two_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !four_screen |-> (mirror_mode == MIR_VERT || mirror_mode == MIR_HORIZ));

endmodule

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int PRG_BANKS  = 16;
    localparam int AW         = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_data = '0;
    logic          cpu_wr = 1'b0;
    logic          four_screen = 1'b0;
    logic [AW-1:0] prg_addr;
    logic [1:0]    mirror_mode;

    prg_bank_mapper #(.PRG_BANKS(PRG_BANKS)) i_prg_bank_mapper (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .cpu_wr (cpu_wr), .four_screen (four_screen),
        .prg_addr (prg_addr), .mirror_mode (mirror_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          is_mir;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model from the requirements
    logic [7:0] m_b0 = 8'd0, m_b1 = 8'd1;
    logic [2:0] m_idx = 3'd0;
    logic       m_swap = 1'b0, m_mir = 1'b0;

    function automatic logic [AW-1:0] exp_addr(input logic [15:0] a);
        logic [3:0] b;
        case (a[14:13])
            2'd0: b = m_swap ? 4'(PRG_BANKS-2) : m_b0[3:0];
            2'd1: b = m_b1[3:0];
            2'd2: b = m_swap ? m_b0[3:0] : 4'(PRG_BANKS-2);
            default: b = 4'(PRG_BANKS-1);
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [1:0] exp_mir();
        return four_screen ? 2'd2 : {1'b0, m_mir};
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) begin
            case ({a[14:13], a[0]})
                3'b000: begin m_idx = d[2:0]; m_swap = d[6]; end
                3'b001: begin
                    if (m_idx == 3'd6) m_b0 = d;
                    if (m_idx == 3'd7) m_b1 = d;
                end
                3'b010: if (!four_screen) m_mir = d[0];
                default: ;
            endcase
        end
    endtask

    // Driver: one strobe, one clock edge high
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        model_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe_addr(input logic [15:0] a, input string tag);
        @(negedge clk);
        cpu_addr = a;
        q.push_back('{1'b0, 32'(exp_addr(a)), tag});
        @(negedge clk);
    endtask

    task automatic probe_mir(input string tag);
        @(negedge clk);
        q.push_back('{1'b1, 32'(exp_mir()), tag});
        @(negedge clk);
    endtask

    task automatic probe_slots(input string tag);
        for (int w = 0; w < 4; w++) begin
            probe_addr(16'h8000 + 16'(w) * 16'h2000 + 16'(w * 16'h0123), tag);
        end
    endtask

    // Monitor: pops expected items and compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_mir ? 32'(mirror_mode) : 32'(prg_addr);
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state (slots 0,1,14,15 and vertical)
        probe_slots("R1 reset mapping");
        probe_mir("R1 reset mirroring");

        // R3, R4, R5: load both switchable banks
        bus_write(16'h8000, 8'h06);
        bus_write(16'h8001, 8'h05);
        bus_write(16'h8000, 8'h07);
        bus_write(16'h8001, 8'h09);
        probe_slots("R4 R5 banks loaded, no swap");

        // R6: swap bit set while keeping index 7
        bus_write(16'h8000, 8'h47);
        probe_slots("R6 swapped mapping");

        // R3: swap cleared again
        bus_write(16'h8000, 8'h06);
        probe_slots("R3 swap cleared");

        // R7: wrap of bank number and offset passthrough
        bus_write(16'h8001, 8'h13);
        probe_addr(16'h9ABC, "R7 wrapped bank0 offset");
        probe_addr(16'hBFFF, "R7 bank1 top byte");

        // R4: index 0..5 writes do not move program banks
        for (int i = 0; i < 6; i++) begin
            bus_write(16'h8000, 8'(i));
            bus_write(16'h8001, 8'h0E);
        end
        probe_slots("R4 character index ignored");

        // R2: aliases 0x9FFE/0x9FFF decode, low half ignored
        bus_write(16'h9FFE, 8'h06);
        bus_write(16'h9FFF, 8'h0A);
        probe_addr(16'h8000, "R2 alias write to bank0");
        bus_write(16'h0001, 8'h0C);
        bus_write(16'h7FFF, 8'h0D);
        probe_addr(16'h8010, "R2 low-half writes ignored");

        // R11: spare registers inert
        bus_write(16'hA001, 8'hFF);
        bus_write(16'hC000, 8'h0F);
        bus_write(16'hC001, 8'h0F);
        bus_write(16'hE000, 8'h41);
        bus_write(16'hE001, 8'h41);
        probe_slots("R11 spare writes no map change");
        probe_mir("R11 spare writes no mirror change");

        // R8: mirroring select
        bus_write(16'hA000, 8'h01);
        probe_mir("R8 horizontal");
        bus_write(16'hA000, 8'hFE);
        probe_mir("R8 vertical");
        bus_write(16'hBFFE, 8'h01);
        probe_mir("R8 horizontal via alias");

        // R9: override and write blocked
        @(negedge clk); four_screen = 1'b1;
        probe_mir("R9 four-screen code");
        bus_write(16'hA000, 8'h00);
        @(negedge clk); four_screen = 1'b0;
        probe_mir("R9 stored bit kept after override");

        // R10: strobe held for three edges, data changing
        bus_write(16'h8000, 8'h06);
        @(negedge clk);
        cpu_addr = 16'h8001; cpu_data = 8'h02; cpu_wr = 1'b1;
        model_write(16'h8001, 8'h02);
        @(negedge clk); cpu_data = 8'h07;
        @(negedge clk); cpu_data = 8'h0B;
        @(negedge clk); cpu_wr = 1'b0;
        probe_addr(16'h8123, "R10 only first edge of held strobe");
        bus_write(16'h8001, 8'h04);
        probe_addr(16'h8123, "R10 next strobe commits");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule